// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one Clause 22 management transaction on an MDIO bus for each command a host writes. The host sees four 32-bit registers: control, configuration, status and command. The command word already has the layout of a management frame, bit for bit. Bits 31:30 hold the start code. Bits 29:28 hold the opcode. Bits 27:23 hold the PHY address and bits 22:18 the register address. Bits 17:16 hold the turnaround and bits 15:0 the data. A host therefore builds the word once, and the block shifts it out unchanged.

A transaction begins with a preamble of ones. The command word follows, most significant bit first, one bit per MDC period. MDC is the system clock divided by one of two ratios. The configuration register picks the ratio, and the block latches it when the transaction starts. On a read, the block releases MDIO at the turnaround and samples the 16 bits that the PHY returns. It writes them into the low half of the command register. A status flag shows when a new command can be accepted. A control enable bit gates the whole port.

Top module: `mdio_master`

## Requirements
- R1: After an accepted command, MDIO carries 32 ones followed by the 32 command bits, MSB first. That is 64 MDC periods, one bit per period.
- R2: MDIO output changes only when MDC falls, so the value is stable at every rising MDC edge.
- R3: Configuration register (address 1) bit 0 picks the MDC period. 0 gives 32 system clocks and 1 gives 48. The choice is sampled when a command is accepted.
- R4: A command with bits 29:28 = 10 is a read. The master drives MDIO for the first 46 bits and releases it (mdio_oe low) for the last 18. These are the two turnaround bits and 16 data bits. It samples mdio_i on the rising MDC edges of the last 16 bits and stores them MSB first in command register bits 15:0. Bits 31:16 are left unchanged.
- R5: Any other opcode (for example 01, write) is driven for all 64 bits. The command register keeps the written value.
- R6: Status register (address 2) bit 2 reads 0 from the cycle after a command is accepted until the frame ends. It reads 1 otherwise. The other bits read 0.
- R7: A write to the command register (address 3) while a transaction runs is ignored. The running frame and the stored command are not changed.
- R8: The port operates only while control register (address 0) bit 4 is 1. A command written while it is 0 is ignored. Clearing the bit during a frame stops the frame: MDC goes low, MDIO is released and the status flag returns to 1.
- R9: After reset all registers read 0 except status, which reads 4. MDC is low and MDIO is released.
- R10: While no transaction runs, MDC stays low and MDIO stays released.
- R11: Register reads return data on host_rdata in the cycle after host_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 2 | Register select: 0 control, 1 configuration, 2 status, 3 command |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low means released |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench targets the turnaround boundary. A master that released MDIO one bit late would contend with the PHY. One that released it early would leave the second turnaround bit undriven on writes, and the frame check would show either fault. Both divider settings are measured edge to edge, because a stale or misdecoded ratio shows up directly as a wrong MDC period. Two misbehaviours are probed through the register readback and the monitored frame: a busy-time write that slips through would corrupt the stored command or start a second frame, and a disabled port that still started would toggle MDC. A read returning a pattern with distinct ends catches a reversed or shifted capture.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W  = 32;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_CFG    = 2'd1,
    RA_STATUS = 2'd2,
    RA_CMD    = 2'd3
  } reg_addr_e;

  localparam int EN_BIT   = 4;
  localparam int IDLE_BIT = 2;
  localparam int DIV_BIT  = 0;
  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_A = 32,
  parameter int DIV_B = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic sel_b,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int DMAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CW   = $clog2(DMAX);
  localparam logic [CW-1:0] LIM_A  = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LIM_B  = CW'(DIV_B - 1);
  localparam logic [CW-1:0] HALF_A = CW'(DIV_A / 2 - 1);
  localparam logic [CW-1:0] HALF_B = CW'(DIV_B / 2 - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim, half;

  assign lim  = sel_b ? LIM_B : LIM_A;
  assign half = sel_b ? HALF_B : HALF_A;
  assign rise = active && (cnt == half);
  assign fall = active && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      if (fall) begin
        cnt <= '0;
        mdc <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (rise) mdc <= 1'b1;
      end
    end
  end

  // R10: MDC parks low whenever the port is not running
  p_mdc_park_r10: assert property (@(posedge clk) disable iff (rst)
    !active |=> !mdc);
  // R2: a falling strobe always takes MDC low
  p_fall_low_r2: assert property (@(posedge clk) disable iff (rst)
    fall |=> !mdc);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
  parameter int PRE_LEN = 32,
  parameter int CMD_W   = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done
);
  import mdio_pkg::*;
  localparam int FRAME  = PRE_LEN + CMD_W;
  localparam int IW     = $clog2(FRAME);
  localparam int TA_IDX = FRAME - DATA_W - 2;
  localparam logic [IW-1:0] LAST    = IW'(FRAME - 1);
  localparam logic [IW-1:0] REL_PRE = IW'(TA_IDX - 1);
  localparam logic [IW-1:0] D_FIRST = IW'(FRAME - DATA_W);

  logic [FRAME-1:0] sh;
  logic [IW-1:0]    idx;
  logic             is_rd;

  assign mdio_o = sh[FRAME-1];

  always_ff @(posedge clk) begin
    rd_done <= 1'b0;
    if (rst) begin
      sh      <= '1;
      idx     <= '0;
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      mdio_oe <= 1'b0;
      rd_data <= '0;
    end else if (abort) begin
      busy    <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      sh      <= {{PRE_LEN{1'b1}}, cmd};
      idx     <= '0;
      busy    <= 1'b1;
      is_rd   <= (cmd[29:28] == OP_READ);
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise && is_rd && idx >= D_FIRST)
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (fall) begin
        sh <= {sh[FRAME-2:0], 1'b1};
        if (idx == LAST) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          rd_done <= is_rd;
        end else begin
          idx <= idx + 1'b1;
          if (is_rd && idx == REL_PRE) mdio_oe <= 1'b0;
        end
      end
    end
  end

  // R2: between falling strobes the driven bit holds
  p_mdio_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !fall) |=> $stable(mdio_o));
  // R10: nothing driven once the frame is over
  p_release_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !mdio_oe);
  // R4: a finished read reports completion only from a busy frame
  p_done_from_busy_r4: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> !busy && $past(busy));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE_LEN = 32,
  parameter int DIV_A   = 32,
  parameter int DIV_B   = 48
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic        host_re,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  logic              en_q, div_cfg_q, div_run_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              busy, start, abort, rise, fall, rd_done;
  logic [DATA_W-1:0] rd_data;
  logic              cmd_wr;

  assign cmd_wr = host_we && (host_addr == RA_CMD);
  assign start  = cmd_wr && en_q && !busy;
  assign abort  = busy && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      div_cfg_q <= 1'b0;
      div_run_q <= 1'b0;
      cmd_q     <= '0;
    end else begin
      if (host_we && host_addr == RA_CTRL) en_q      <= host_wdata[EN_BIT];
      if (host_we && host_addr == RA_CFG)  div_cfg_q <= host_wdata[DIV_BIT];
      if (start) begin
        cmd_q     <= host_wdata;
        div_run_q <= div_cfg_q;
      end else if (rd_done) begin
        cmd_q[DATA_W-1:0] <= rd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_re) begin
      host_rdata <= '0;
      case (host_addr)
        RA_CTRL:   host_rdata[EN_BIT]   <= en_q;
        RA_CFG:    host_rdata[DIV_BIT]  <= div_cfg_q;
        RA_STATUS: host_rdata[IDLE_BIT] <= !busy;
        default:   host_rdata           <= cmd_q;
      endcase
    end
  end

  mdio_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_clk (
    .clk(clk), .rst(rst), .active(busy), .sel_b(div_run_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .cmd(host_wdata),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(busy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data), .rd_done(rd_done)
  );

  // R6: an accepted command makes the port busy on the next cycle
  p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  // R7: a command write during a frame leaves the stored command alone
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> $stable(cmd_q[CMD_W-1:DATA_W]));
  // R8: with the enable clear the port is idle one cycle later
  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !busy);
  // R4: read completion keeps the address half of the command
  p_rd_keep_hi_r4: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> $stable(cmd_q[CMD_W-1:DATA_W]));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0, bad = 0;

  typedef struct packed {
    logic [63:0] frame;
    logic [63:0] oe;
    logic [7:0]  div;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        cur;
  logic [15:0] phy_resp = '0;
  bit          mon_on = 1'b1;
  int          bcnt = 0;
  int          cyc = 0, last_rise = 0;
  bit          per_bad;
  logic        mdc_prev = 1'b0;
  logic [63:0] obs_o, obs_oe;

  always #10 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = '0;
    while (!s[2]) rd(2'd2, s);
  endtask

  // driver: push what the frame should look like, then issue the command
  task automatic issue(input logic [31:0] cmd, input bit div48,
                       input logic [15:0] resp);
    exp_t e;
    e.frame = {32'hFFFF_FFFF, cmd};
    e.oe    = '1;
    if (cmd[29:28] == 2'b10) e.oe[17:0] = '0;
    e.div   = div48 ? 8'd48 : 8'd32;
    sb_q.push_back(e);
    phy_resp = resp;
    wr(2'd1, {31'd0, div48});
    wr(2'd3, cmd);
  endtask

  // monitor and PHY model, all sampling at the falling system clock edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (mon_on && mdc && !mdc_prev) begin
        if (bcnt == 0) begin
          per_bad = 1'b0;
          if (sb_q.size() == 0) begin
            chk(1'b0, "R10 unexpected frame", 64'd1, 64'd0);
            cur = '0;
          end else cur = sb_q.pop_front();
        end else if (cyc - last_rise != int'(cur.div)) per_bad = 1'b1;
        last_rise = cyc;
        obs_o[63-bcnt]  = mdio_o;
        obs_oe[63-bcnt] = mdio_oe;
        bcnt++;
        if (bcnt == 64) begin
          chk(!per_bad, "R3 mdc period", 64'(cyc - last_rise), 64'(cur.div));
          chk(obs_oe == cur.oe, "R4/R5 drive window", obs_oe, cur.oe);
          chk(((obs_o ^ cur.frame) & cur.oe) == 0, "R1/R2 frame bits",
              obs_o, cur.frame);
          bcnt = 0;
        end
      end
      if (mon_on && !mdc && mdc_prev)
        mdio_i = (bcnt >= 48) ? phy_resp[63-bcnt] : 1'b1;
      mdc_prev = mdc;
    end
  end

  initial begin
    #3000000;
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] c;
    int hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    rd(2'd0, d); chk(d == 0, "R9 ctrl reset", 64'(d), 64'd0);
    rd(2'd1, d); chk(d == 0, "R9 cfg reset", 64'(d), 64'd0);
    rd(2'd2, d); chk(d == 32'd4, "R9/R11 status reset", 64'(d), 64'd4);
    rd(2'd3, d); chk(d == 0, "R9 cmd reset", 64'(d), 64'd0);
    chk(!mdc && !mdio_oe, "R9 pins reset", {62'd0, mdc, mdio_oe}, 64'd0);

    // R8 disabled port ignores a command
    wr(2'd3, 32'h5012_ABCD);
    hi = 0;
    repeat (200) begin @(negedge clk); if (mdc) hi++; end
    chk(hi == 0, "R8 no mdc when disabled", 64'(hi), 64'd0);
    rd(2'd3, d); chk(d == 0, "R8 cmd ignored when disabled", 64'(d), 64'd0);
    rd(2'd2, d); chk(d[2], "R8 idle when disabled", 64'(d), 64'd4);

    wr(2'd0, 32'h10);
    rd(2'd0, d); chk(d == 32'h10, "R11 ctrl readback", 64'(d), 64'h10);

    // R5 write frame, divide by 32, with a busy-time write (R7)
    c = 32'h4002_0000 | (32'd1 << 28) | (32'd5 << 23) | (32'd3 << 18) | 32'hBEEF;
    issue(c, 1'b0, 16'h0000);
    rd(2'd2, d); chk(d == 0, "R6 busy flag", 64'(d), 64'd0);
    wr(2'd3, 32'h6FFE_1234);
    wait_idle();
    rd(2'd3, d); chk(d == c, "R5/R7 cmd kept", 64'(d), 64'(c));
    rd(2'd2, d); chk(d == 32'd4, "R6 idle after frame", 64'(d), 64'd4);
    hi = 0;
    repeat (100) begin @(negedge clk); if (mdc || mdio_oe) hi++; end
    chk(hi == 0, "R10 quiet when idle", 64'(hi), 64'd0);

    // R4 read, divide by 48
    c = 32'h4002_0000 | (32'd1 << 29) | (32'd31 << 23) | (32'd1 << 18);
    issue(c, 1'b1, 16'hA5C3);
    wait_idle();
    rd(2'd3, d);
    chk(d == {c[31:16], 16'hA5C3}, "R4 read capture", 64'(d),
        64'({c[31:16], 16'hA5C3}));

    // R4 read, edge pattern, divide by 32
    c = 32'h4002_0000 | (32'd1 << 29) | (32'd31 << 18);
    issue(c, 1'b0, 16'h8001);
    wait_idle();
    rd(2'd3, d);
    chk(d == {c[31:16], 16'h8001}, "R4 read msb first", 64'(d),
        64'({c[31:16], 16'h8001}));

    // R8 clearing the enable mid-frame stops it
    mon_on = 1'b0;
    wr(2'd1, 32'd0);
    wr(2'd3, 32'h5082_0F0F);
    repeat (100) @(negedge clk);
    wr(2'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe, "R8 abort pins", {62'd0, mdc, mdio_oe}, 64'd0);
    rd(2'd2, d); chk(d == 32'd4, "R8 abort idle", 64'(d), 64'd4);
    bcnt = 0;
    mdc_prev = 1'b0;
    mon_on = 1'b1;

    // port recovers after re-enable
    wr(2'd0, 32'h10);
    c = 32'h4002_0000 | (32'd1 << 28) | (32'd10 << 23) | (32'd20 << 18) | 32'h0F0F;
    issue(c, 1'b1, 16'h0000);
    wait_idle();
    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0 && bcnt == 0, "R1 all frames seen",
        64'(sb_q.size()), 64'd0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule